// File: doc/BRIEF.md
# Banked Mode-Register Pointer Unit

This block holds the three mode registers of each channel of a two-channel serial controller. All three registers of a channel sit behind one bus address, and a hidden pointer per channel picks which one a read or write reaches. Each access to that address moves the pointer one step forward, and the pointer stops at the last register. It can only be moved back by writing one of two recognised codes to the same channel's command register.

A host reaches a given register by first writing a pointer-rewind code to the command register. It then issues as many mode-address accesses as needed to step to the register it wants. The bit meaning of the mode registers is left to the logic that uses them.

Each channel's pointer is a three-state machine with states `SEL_M0`, `SEL_M1` and `SEL_M2`:
- Transition `STEP`: a mode access moves `SEL_M0` to `SEL_M1`, and `SEL_M1` to `SEL_M2`.
- Transition `HOLD`: a mode access leaves `SEL_M2` in `SEL_M2`.
- Transition `REWIND0`: command code 0xB0 goes to `SEL_M0` from any state.
- Transition `REWIND1`: command code 0x10 goes to `SEL_M1` from any state.
- Reset enters `SEL_M1`.

Top module: `mrsel_bank`

## Requirements
- R1: After reset, each channel's pointer selects its middle register (register 1), and all six mode registers hold 0x00.
- R2: A write (wr_en high) to a channel's mode address stores wdata into the register the pointer selects. The pointer then advances one step at that clock edge. The mode address is 0x0 for channel A and 0x8 for channel B.
- R3: While rd_en is high at a channel's mode address, rdata shows the register selected before the access in the same cycle. The pointer advances at the clock edge that ends the access.
- R4: The pointer saturates: when it is at register 2, further mode accesses stay on register 2.
- R5: Writing 0xB0 to a channel's command address moves that channel's pointer to register 0. The command address is 0x2 for channel A and 0xA for channel B.
- R6: Writing 0x10 to a channel's command address moves that channel's pointer to register 1.
- R7: Writing any other value to a command address leaves the pointer unchanged.
- R8: Accesses and commands on one channel do not change the other channel's pointer or registers.
- R9: rdata is 0x00 whenever rd_en is low or the address is not a mode address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 4 | Register address |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |

## Verification
Channel A is driven with several kinds of access runs:
- Runs of consecutive writes, which separate a pointer that stops at register 2 from one that wraps or stalls.
- Reads placed after each rewind code, which show whether the read value is taken before or after the step.
- A write of an unrecognised command code followed by a read, which exposes any decoding of partial codes.

Channel B is then driven while channel A holds a known pointer, and the reverse, so that a shared or cross-wired pointer is caught. A reset in the middle of the run shows that the pointer returns to register 1 rather than to register 0.

// File: rtl/mrsel_pkg.sv
package mrsel_pkg;
    localparam int PTR_W = 2;

    typedef enum logic [PTR_W-1:0] {
        SEL_M0 = 2'd0,
        SEL_M1 = 2'd1,
        SEL_M2 = 2'd2
    } mrsel_state_t;

    localparam int NUM_MR = 3;
endpackage

// File: rtl/mrsel_ptr_fsm.sv
module mrsel_ptr_fsm
    import mrsel_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_i,
    input  logic              rew0_i,
    input  logic              rew1_i,
    output mrsel_state_t      state_o,
    output logic [NUM_MR-1:0] sel_oh_o
);
    mrsel_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (rew0_i) begin
            state_d = SEL_M0;                 // REWIND0
        end else if (rew1_i) begin
            state_d = SEL_M1;                 // REWIND1
        end else if (acc_i) begin
            unique case (state_q)
                SEL_M0:  state_d = SEL_M1;    // STEP
                SEL_M1:  state_d = SEL_M2;    // STEP
                SEL_M2:  state_d = SEL_M2;    // HOLD
                default: state_d = SEL_M1;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SEL_M1;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        sel_oh_o = '0;
        unique case (state_q)
            SEL_M0:  sel_oh_o[0] = 1'b1;
            SEL_M1:  sel_oh_o[1] = 1'b1;
            SEL_M2:  sel_oh_o[2] = 1'b1;
            default: sel_oh_o = '0;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/mrsel_regfile.sv
module mrsel_regfile
    import mrsel_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_MR-1:0] sel_oh_i,
    input  logic              we_i,
    input  logic [DW-1:0]     wdata_i,
    output logic [DW-1:0]     rdata_o
);
    logic [NUM_MR-1:0][DW-1:0] mr_q;

    for (genvar r = 0; r < NUM_MR; r++) begin : g_reg
        always_ff @(posedge clk) begin
            if (!rst_n)                    mr_q[r] <= '0;
            else if (we_i && sel_oh_i[r]) mr_q[r] <= wdata_i;
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int r = 0; r < NUM_MR; r++) begin
            if (sel_oh_i[r]) rdata_o = rdata_o | mr_q[r];
        end
    end
endmodule

// File: rtl/mrsel_bank.sv
module mrsel_bank
    import mrsel_pkg::*;
#(
    parameter int          NUM_CH    = 2,
    parameter int          AW        = 4,
    parameter int          DW        = 8,
    parameter int          CH_STRIDE = 8,
    parameter int          MODE_OFS  = 0,
    parameter int          CMD_OFS   = 2,
    parameter logic [7:0]  CODE_REW0 = 8'hB0,
    parameter logic [7:0]  CODE_REW1 = 8'h10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          rd_en,
    input  logic          wr_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [NUM_CH-1:0][PTR_W-1:0] ptr_vec;
    logic [NUM_CH-1:0][DW-1:0]    ch_rdata;
    logic [NUM_CH-1:0]            ch_rd;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        localparam logic [AW-1:0] MODE_A = AW'(c * CH_STRIDE + MODE_OFS);
        localparam logic [AW-1:0] CMD_A  = AW'(c * CH_STRIDE + CMD_OFS);

        logic              hit_mode, hit_cmd, acc, rew0, rew1;
        logic [NUM_MR-1:0] sel_oh;
        logic [DW-1:0]     rf_rdata;
        mrsel_state_t      st;

        assign hit_mode = (addr == MODE_A);
        assign hit_cmd  = (addr == CMD_A);
        assign acc      = hit_mode && (rd_en || wr_en);
        assign rew0     = hit_cmd && wr_en && (wdata == DW'(CODE_REW0));
        assign rew1     = hit_cmd && wr_en && (wdata == DW'(CODE_REW1));

        mrsel_ptr_fsm u_fsm (
            .clk      (clk),
            .rst_n    (rst_n),
            .acc_i    (acc),
            .rew0_i   (rew0),
            .rew1_i   (rew1),
            .state_o  (st),
            .sel_oh_o (sel_oh)
        );

        mrsel_regfile #(.DW(DW)) u_rf (
            .clk      (clk),
            .rst_n    (rst_n),
            .sel_oh_i (sel_oh),
            .we_i     (hit_mode && wr_en),
            .wdata_i  (wdata),
            .rdata_o  (rf_rdata)
        );

        assign ptr_vec[c]  = st;
        assign ch_rd[c]    = hit_mode && rd_en;
        assign ch_rdata[c] = ch_rd[c] ? rf_rdata : '0;
    end

    always_comb begin
        rdata = '0;
        for (int c = 0; c < NUM_CH; c++) rdata = rdata | ch_rdata[c];
    end
endmodule

// File: rtl/mrsel_bank_chk.sv
module mrsel_bank_chk #(
    parameter int          NUM_CH    = 2,
    parameter int          AW        = 4,
    parameter int          DW        = 8,
    parameter int          CH_STRIDE = 8,
    parameter int          MODE_OFS  = 0,
    parameter int          CMD_OFS   = 2,
    parameter logic [7:0]  CODE_REW0 = 8'hB0,
    parameter logic [7:0]  CODE_REW1 = 8'h10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [AW-1:0]           addr,
    input logic                    rd_en,
    input logic                    wr_en,
    input logic [DW-1:0]           wdata,
    input logic [DW-1:0]           rdata,
    input logic [NUM_CH-1:0][1:0]  ptr_vec
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        localparam logic [AW-1:0] MA = AW'(c * CH_STRIDE + MODE_OFS);
        localparam logic [AW-1:0] CA = AW'(c * CH_STRIDE + CMD_OFS);

        assert_legal_ptr_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ptr_vec[c] != 2'd3);

        assert_rewind0_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CA && wdata == DW'(CODE_REW0)) |=> ptr_vec[c] == 2'd0);

        assert_rewind1_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && addr == CA && wdata == DW'(CODE_REW1)) |=> ptr_vec[c] == 2'd1);

        assert_other_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && !rd_en && addr == CA && wdata != DW'(CODE_REW0)
             && wdata != DW'(CODE_REW1)) |=> $stable(ptr_vec[c]));

        assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_en || wr_en) && addr == MA && ptr_vec[c] == 2'd0) |=> ptr_vec[c] == 2'd1);

        assert_saturate_R4: assert property (@(posedge clk) disable iff (!rst_n)
            ((rd_en || wr_en) && addr == MA && ptr_vec[c] == 2'd2) |=> ptr_vec[c] == 2'd2);

        assert_isolated_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (addr != MA && addr != CA) |=> $stable(ptr_vec[c]));
    end

    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rdata == '0);
endmodule

bind mrsel_bank mrsel_bank_chk #(
    .NUM_CH(NUM_CH), .AW(AW), .DW(DW), .CH_STRIDE(CH_STRIDE),
    .MODE_OFS(MODE_OFS), .CMD_OFS(CMD_OFS),
    .CODE_REW0(CODE_REW0), .CODE_REW1(CODE_REW1)
) chk_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .ptr_vec(ptr_vec)
);

// File: tb/mrsel_bank_tb_top.sv
module mrsel_bank_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [3:0] addr;
    logic       rd_en, wr_en;
    logic [7:0] wdata;
    logic [7:0] rdata;
    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk; // 250 MHz

    mrsel_bank dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .rd_en(rd_en),
        .wr_en(wr_en), .wdata(wdata), .rdata(rdata)
    );

    // op: 0 write, 1 read (check), 2 idle (check rdata)
    // fields: {op[1:0], addr[3:0], data[7:0], expect[7:0], req[3:0]}
    localparam int NV = 24;
    localparam logic [25:0] VEC [NV] = '{
        {2'd0, 4'h0, 8'h11, 8'h00, 4'd2}, // R2 write MR1A
        {2'd0, 4'h0, 8'h22, 8'h00, 4'd2}, // R2 write MR2A
        {2'd0, 4'h0, 8'h33, 8'h00, 4'd4}, // R4 saturated overwrite MR2A
        {2'd0, 4'h2, 8'hB0, 8'h00, 4'd5}, // R5 rewind to 0
        {2'd0, 4'h0, 8'h44, 8'h00, 4'd5}, // R5 write MR0A
        {2'd0, 4'h2, 8'h10, 8'h00, 4'd6}, // R6 rewind to 1
        {2'd1, 4'h0, 8'h00, 8'h11, 4'd6}, // R6 read MR1A
        {2'd1, 4'h0, 8'h00, 8'h33, 4'd4}, // R4 read MR2A
        {2'd1, 4'h0, 8'h00, 8'h33, 4'd4}, // R4 stays at MR2A
        {2'd0, 4'h2, 8'hB0, 8'h00, 4'd5}, // R5
        {2'd1, 4'h0, 8'h00, 8'h44, 4'd3}, // R3 read MR0A then step
        {2'd1, 4'h0, 8'h00, 8'h11, 4'd3}, // R3 read MR1A
        {2'd0, 4'h2, 8'h20, 8'h00, 4'd7}, // R7 unknown code
        {2'd0, 4'h2, 8'hB1, 8'h00, 4'd7}, // R7 near-miss code
        {2'd1, 4'h0, 8'h00, 8'h33, 4'd7}, // R7 still MR2A
        {2'd1, 4'h8, 8'h00, 8'h00, 4'd8}, // R8 chB at MR1B from reset
        {2'd0, 4'h8, 8'h55, 8'h00, 4'd8}, // R8 write MR2B
        {2'd0, 4'h2, 8'hB0, 8'h00, 4'd8}, // R8 rewind chA only
        {2'd1, 4'h8, 8'h00, 8'h55, 4'd8}, // R8 chB still MR2B
        {2'd0, 4'hA, 8'hB0, 8'h00, 4'd5}, // R5 rewind chB
        {2'd0, 4'h8, 8'h66, 8'h00, 4'd8}, // R8 write MR0B
        {2'd1, 4'h0, 8'h00, 8'h44, 4'd8}, // R8 chA at MR0A
        {2'd1, 4'h8, 8'h00, 8'h00, 4'd8}, // R8 chB MR1B untouched
        {2'd2, 4'h0, 8'h00, 8'h00, 4'd9}  // R9 idle -> zero
    };

    task automatic check(input logic [7:0] exp, input int req, input string what);
        n_chk++;
        if (rdata !== exp) begin
            n_bad++;
            $display("FAIL R%0d %s: rdata=%h expected=%h", req, what, rdata, exp);
        end
    endtask

    // drive at negedge, check mid-low phase, commit at next posedge
    task automatic access(input logic [1:0] op, input logic [3:0] a,
                          input logic [7:0] d, input logic [7:0] exp, input int req);
        @(negedge clk);
        addr  = a;
        wdata = d;
        wr_en = (op == 2'd0);
        rd_en = (op == 2'd1);
        #1;
        if (op != 2'd0) check(exp, req, "vector");
    endtask

    initial begin : watchdog
        #100000;
        n_bad++;
        $display("FAIL R0 watchdog expired: actual=hang expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; addr = '0; rd_en = 0; wr_en = 0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state, reading registers 1, 2 of chA, then rewind to 0
        access(2'd1, 4'h0, 8'h00, 8'h00, 1); // R1 MR1A = 0
        access(2'd1, 4'h0, 8'h00, 8'h00, 1); // R1 MR2A = 0
        access(2'd0, 4'h2, 8'hB0, 8'h00, 1);
        access(2'd1, 4'h0, 8'h00, 8'h00, 1); // R1 MR0A = 0
        access(2'd0, 4'h2, 8'h10, 8'h00, 1); // back to MR1A for the table

        for (int i = 0; i < NV; i++) begin
            access(VEC[i][25:24], VEC[i][23:20], VEC[i][19:12],
                   VEC[i][11:4], int'(VEC[i][3:0]));
        end

        // R9: read strobe on a non-mode address
        access(2'd1, 4'h5, 8'h00, 8'h00, 9);
        access(2'd1, 4'h2, 8'h00, 8'h00, 9);

        // R1: mid-run reset returns the pointer to register 1, data to zero
        @(negedge clk); rd_en = 0; wr_en = 0; rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        access(2'd0, 4'h0, 8'h77, 8'h00, 1);   // lands in MR1A
        access(2'd0, 4'hA, 8'hB0, 8'h00, 1);
        access(2'd1, 4'h8, 8'h00, 8'h00, 1);   // MR0B reset to 0
        access(2'd0, 4'h2, 8'h10, 8'h00, 1);
        access(2'd1, 4'h0, 8'h00, 8'h77, 1);   // R1 write hit MR1A
        access(2'd0, 4'h2, 8'hB0, 8'h00, 1);
        access(2'd1, 4'h0, 8'h00, 8'h00, 1);   // R1 MR0A untouched

        // R3: simultaneous read and write reads old value, step once
        access(2'd1, 4'h0, 8'h00, 8'h77, 3);   // now at MR2A
        @(negedge clk); addr = 4'h0; rd_en = 1; wr_en = 1; wdata = 8'h99; #1;
        check(8'h00, 3, "read during write");
        access(2'd1, 4'h0, 8'h00, 8'h99, 3);

        @(negedge clk); rd_en = 0; wr_en = 0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule